// File: doc/BRIEF.md
# System Control Register File

This block holds the privileged control registers of a processor core: translation-entry staging registers, the timer count and compare pair, status, cause, and the two saved return addresses. Software reaches them through a move-to port and a move-from port. Both take a 5-bit register number and a 3-bit select. Every write is merged through a bit mask specific to the target register, so read-only and reserved fields keep their values. A few register numbers return fixed identification words.

The block also carries out the exception-return command. It chooses the saved address to resume from and clears the matching status bit. It then signals the fetch unit with a PC-load strobe and signals the memory side with a link-bit clear. A write to the compare register withdraws a pending timer interrupt. An undefined register number or select raises a one-cycle invalid-access flag and changes nothing. Counting, exception entry and privilege checking belong to other blocks.

All outputs are registered. Read data, the flags and the return strobes appear in the cycle after the request.

Top module: `sysctl_regfile`

## Requirements
- R1: Reset sets every register to zero, except the Status word, which reads 0x00000004 because the error-level bit (bit 2) is set. After reset `timerIrq`, `pcLoad`, `linkClr`, `rdValid` and `badAccess` are low.
- R2: A read request with a valid number and select gives `rdValid` high and the register value on `rdData` one cycle later. An invalid read gives no `rdValid`.
- R3: Register 0 (index) stores only bits 3:0 of the written word and keeps bit 31. Register 6 (wired) stores only bits 3:0. Both accept select 0 only.
- R4: Registers 2 and 3 (entry-low pair) store bits 25:0 and ignore the select. Register 10 (entry-high) stores the word with bits 12:8 forced to zero.
- R5: A write to register 4 (context) changes only bits 31:23 and keeps bits 22:0.
- R6: Register 12 (status) takes only the bits set in 0x7D7CFF17. Register 13 (cause) takes only bits 23, 22 and 15:8.
- R7: `timerEvent` sets the pending timer interrupt, which `timerIrq` shows in the next cycle. A write to register 11 (compare) clears it, and the clear wins over a simultaneous event.
- R8: Register 5 (page mask) accepts only zero. A nonzero write pulses `unsupFlag` for one cycle and leaves the register unchanged.
- R9: Register 15 reads 0x00018000 with any select. Register 16 reads a first configuration word with select 0 and a second one with select 1; the defaults are 0x80008082 and 0x1E190C8A. Registers 18 and 19 read zero with any select. Writes to 16, 18 and 19 are accepted and have no effect.
- R10: An access to an unimplemented number, or a nonzero select where the register does not allow one, pulses `badAccess` one cycle later and alters no register. Register 30 holds the error return address, with select 0.
- R11: An exception return issued with `inDelaySlot` high does nothing: no `pcLoad`, no `linkClr`, and Status is unchanged.
- R12: An exception return while the error-level bit is set gives `pcLoad` and `linkClr` for one cycle with `nextPc` equal to register 30, and clears the error-level bit.
- R13: An exception return while the error-level bit is clear gives `nextPc` equal to register 14 and clears the exception-level bit (Status bit 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Move-to request |
| rdEn | input | 1 | Move-from request |
| regNum | input | 5 | Register number |
| regSel | input | 3 | Register select |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data |
| rdValid | output | 1 | Read data valid (write-back allowed) |
| retCmd | input | 1 | Exception-return command |
| inDelaySlot | input | 1 | Return issued in a branch delay slot |
| nextPc | output | 32 | Resume address |
| pcLoad | output | 1 | Load `nextPc` into the PC |
| linkClr | output | 1 | Clear the load-linked bit |
| timerEvent | input | 1 | Count reached Compare |
| timerIrq | output | 1 | Pending timer interrupt |
| badAccess | output | 1 | Undefined register or select |
| unsupFlag | output | 1 | Unsupported page-mask value written |

## Verification
The bench builds the block with its default parameters. These give a 4-bit index field and the standard identification words, so the fixed read values and the index and wired truncation can be checked against known constants. Random write-then-read pairs across all writable registers exercise every merge mask against arbitrary data. Directed sequences cover both return paths, the delay-slot suppression, the unsupported page mask and the undefined selects.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int XLEN   = 32;
  localparam int NUM_WR = 13;
  localparam int IW     = $clog2(NUM_WR);
  localparam int SLOTS  = 2 ** IW;

  // storage slot numbers
  localparam int WI_INDEX  = 0;
  localparam int WI_LO0    = 1;
  localparam int WI_LO1    = 2;
  localparam int WI_CTX    = 3;
  localparam int WI_PGM    = 4;
  localparam int WI_WIRED  = 5;
  localparam int WI_COUNT  = 6;
  localparam int WI_HI     = 7;
  localparam int WI_CMP    = 8;
  localparam int WI_STATUS = 9;
  localparam int WI_CAUSE  = 10;
  localparam int WI_EPC    = 11;
  localparam int WI_ERREPC = 12;

  // architectural register numbers (software-visible)
  localparam logic [4:0] RN_INDEX  = 5'd0;
  localparam logic [4:0] RN_LO0    = 5'd2;
  localparam logic [4:0] RN_LO1    = 5'd3;
  localparam logic [4:0] RN_CTX    = 5'd4;
  localparam logic [4:0] RN_PGM    = 5'd5;
  localparam logic [4:0] RN_WIRED  = 5'd6;
  localparam logic [4:0] RN_BADV   = 5'd8;
  localparam logic [4:0] RN_COUNT  = 5'd9;
  localparam logic [4:0] RN_HI     = 5'd10;
  localparam logic [4:0] RN_CMP    = 5'd11;
  localparam logic [4:0] RN_STATUS = 5'd12;
  localparam logic [4:0] RN_CAUSE  = 5'd13;
  localparam logic [4:0] RN_EPC    = 5'd14;
  localparam logic [4:0] RN_PRID   = 5'd15;
  localparam logic [4:0] RN_CFG    = 5'd16;
  localparam logic [4:0] RN_Z0     = 5'd18;
  localparam logic [4:0] RN_Z1     = 5'd19;
  localparam logic [4:0] RN_ERREPC = 5'd30;

  localparam int ERL_BIT = 2;
  localparam int EXL_BIT = 1;
  localparam logic [XLEN-1:0] ERL_MASK  = XLEN'(1) << ERL_BIT;
  localparam logic [XLEN-1:0] EXL_MASK  = XLEN'(1) << EXL_BIT;
  localparam logic [XLEN-1:0] STATUS_WR = 32'h7D7C_FF17;
  localparam logic [XLEN-1:0] CAUSE_WR  = 32'h00C0_FF00;
  localparam logic [XLEN-1:0] CTX_WR    = 32'hFF80_0000;
  localparam logic [XLEN-1:0] LO_WR     = 32'h03FF_FFFF;
  localparam logic [XLEN-1:0] HI_WR     = ~32'h0000_1F00;
  localparam logic [XLEN-1:0] PGM_WR    = 32'h01FF_E000;
  localparam logic [XLEN-1:0] IDX_KEEP  = 32'h8000_0000;

  typedef enum logic [2:0] {
    SRC_ZERO, SRC_REG, SRC_PRID, SRC_CFG0, SRC_CFG1
  } rdSrc_e;

  typedef struct packed {
    logic [NUM_WR-1:0] wrHit;
    logic              pgmBad;
    logic              rdHit;
    rdSrc_e            rdSrc;
    logic [IW-1:0]     rdIdx;
    logic              doRet;
    logic              bad;
  } ctrlStrobe_t;

  function automatic logic [XLEN-1:0] wrMaskOf(int idx, int fieldBits);
    logic [XLEN-1:0] low;
    low = (XLEN'(1) << fieldBits) - XLEN'(1);
    case (idx)
      WI_INDEX, WI_WIRED: return low;
      WI_LO0, WI_LO1:     return LO_WR;
      WI_CTX:             return CTX_WR;
      WI_PGM:             return PGM_WR;
      WI_HI:              return HI_WR;
      WI_STATUS:          return STATUS_WR;
      WI_CAUSE:           return CAUSE_WR;
      default:            return '1;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] keepMaskOf(int idx);
    case (idx)
      WI_INDEX:  return IDX_KEEP;
      WI_CTX:    return ~CTX_WR;
      WI_STATUS: return ~STATUS_WR;
      WI_CAUSE:  return ~CAUSE_WR;
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_mreg.sv
module sysctl_mreg
  import sysctl_pkg::*;
#(
  parameter logic [XLEN-1:0] WR_MASK   = '1,
  parameter logic [XLEN-1:0] KEEP_MASK = '0,
  parameter logic [XLEN-1:0] RST_VAL   = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [XLEN-1:0] wrData,
  input  logic [XLEN-1:0] clrMask,
  output logic [XLEN-1:0] q
);
  logic [XLEN-1:0] merged;

  always_comb begin
    merged = wrEn ? ((q & KEEP_MASK) | (wrData & WR_MASK)) : q;
    merged = merged & ~clrMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) q <= RST_VAL;
    else       q <= merged;
  end
endmodule

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic            rdEn,
  input  logic [4:0]      regNum,
  input  logic [2:0]      regSel,
  input  logic [XLEN-1:0] wrData,
  input  logic            retCmd,
  input  logic            inDelaySlot,
  output ctrlStrobe_t     st
);
  logic          selZero;
  logic          wOk, wStore, rOk;
  logic [IW-1:0] wIdx, rIdx;
  rdSrc_e        rSrc;

  assign selZero = (regSel == 3'd0);

  always_comb begin
    wOk = 1'b0; wStore = 1'b0; wIdx = '0;
    rOk = 1'b0; rSrc = SRC_ZERO; rIdx = '0;
    case (regNum)
      RN_INDEX:  begin wOk = selZero; wStore = 1'b1; wIdx = IW'(WI_INDEX);
                       rOk = selZero; rSrc = SRC_REG; rIdx = IW'(WI_INDEX); end
      RN_LO0:    begin wOk = 1'b1; wStore = 1'b1; wIdx = IW'(WI_LO0);
                       rOk = 1'b1; rSrc = SRC_REG; rIdx = IW'(WI_LO0); end
      RN_LO1:    begin wOk = 1'b1; wStore = 1'b1; wIdx = IW'(WI_LO1);
                       rOk = 1'b1; rSrc = SRC_REG; rIdx = IW'(WI_LO1); end
      RN_CTX:    begin wOk = 1'b1; wStore = 1'b1; wIdx = IW'(WI_CTX);
                       rOk = selZero; rSrc = SRC_REG; rIdx = IW'(WI_CTX); end
      RN_PGM:    begin wOk = selZero; wStore = 1'b1; wIdx = IW'(WI_PGM);
                       rOk = selZero; rSrc = SRC_REG; rIdx = IW'(WI_PGM); end
      RN_WIRED:  begin wOk = selZero; wStore = 1'b1; wIdx = IW'(WI_WIRED);
                       rOk = selZero; rSrc = SRC_REG; rIdx = IW'(WI_WIRED); end
      RN_BADV:   begin rOk = selZero; rSrc = SRC_ZERO; end
      RN_COUNT:  begin wOk = selZero; wStore = 1'b1; wIdx = IW'(WI_COUNT);
                       rOk = selZero; rSrc = SRC_REG; rIdx = IW'(WI_COUNT); end
      RN_HI:     begin wOk = selZero; wStore = 1'b1; wIdx = IW'(WI_HI);
                       rOk = selZero; rSrc = SRC_REG; rIdx = IW'(WI_HI); end
      RN_CMP:    begin wOk = selZero; wStore = 1'b1; wIdx = IW'(WI_CMP);
                       rOk = selZero; rSrc = SRC_REG; rIdx = IW'(WI_CMP); end
      RN_STATUS: begin wOk = selZero; wStore = 1'b1; wIdx = IW'(WI_STATUS);
                       rOk = selZero; rSrc = SRC_REG; rIdx = IW'(WI_STATUS); end
      RN_CAUSE:  begin wOk = selZero; wStore = 1'b1; wIdx = IW'(WI_CAUSE);
                       rOk = selZero; rSrc = SRC_REG; rIdx = IW'(WI_CAUSE); end
      RN_EPC:    begin wOk = selZero; wStore = 1'b1; wIdx = IW'(WI_EPC);
                       rOk = selZero; rSrc = SRC_REG; rIdx = IW'(WI_EPC); end
      RN_ERREPC: begin wOk = selZero; wStore = 1'b1; wIdx = IW'(WI_ERREPC);
                       rOk = selZero; rSrc = SRC_REG; rIdx = IW'(WI_ERREPC); end
      RN_PRID:   begin rOk = 1'b1; rSrc = SRC_PRID; end
      RN_CFG:    begin wOk = 1'b1;
                       rOk = (regSel <= 3'd1);
                       rSrc = (regSel == 3'd1) ? SRC_CFG1 : SRC_CFG0; end
      RN_Z0, RN_Z1: begin wOk = 1'b1; rOk = 1'b1; rSrc = SRC_ZERO; end
      default: ;
    endcase
  end

  always_comb begin
    st = '0;
    for (int i = 0; i < NUM_WR; i++) begin
      st.wrHit[i] = wrEn && wOk && wStore && (int'(wIdx) == i)
                    && !((i == WI_PGM) && (wrData != '0));
    end
    st.pgmBad = wrEn && wOk && wStore && (int'(wIdx) == WI_PGM) && (wrData != '0);
    st.rdHit  = rdEn && rOk;
    st.rdSrc  = rSrc;
    st.rdIdx  = rIdx;
    st.doRet  = retCmd && !inDelaySlot;
    st.bad    = (wrEn && !wOk) || (rdEn && !rOk);
  end

  // R10
  bad_write_no_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdEn && st.bad) |-> (st.wrHit == '0));

  // R8
  pgm_nonzero_no_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.pgmBad |-> !st.wrHit[WI_PGM]);
endmodule

// File: rtl/sysctl_dp.sv
module sysctl_dp
  import sysctl_pkg::*;
#(
  parameter int              INDEX_BITS = 4,
  parameter logic [XLEN-1:0] PRID_VAL   = 32'h0001_8000,
  parameter logic [XLEN-1:0] CFG0_VAL   = 32'h8000_8082,
  parameter logic [XLEN-1:0] CFG1_VAL   = 32'h1E19_0C8A
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     st,
  input  logic [XLEN-1:0] wrData,
  input  logic            timerEvent,
  output logic [XLEN-1:0] rdData,
  output logic            rdValid,
  output logic [XLEN-1:0] nextPc,
  output logic            pcLoad,
  output logic            linkClr,
  output logic            timerIrq,
  output logic            badAccess,
  output logic            unsupFlag
);
  logic [XLEN-1:0] regQ [SLOTS];
  logic [XLEN-1:0] retClr;
  logic [XLEN-1:0] rdMux;
  logic            erlNow;

  assign erlNow = regQ[WI_STATUS][ERL_BIT];
  assign retClr = st.doRet ? (erlNow ? ERL_MASK : EXL_MASK) : '0;

  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    if (g < NUM_WR) begin : gReg
      sysctl_mreg #(
        .WR_MASK  (wrMaskOf(g, INDEX_BITS)),
        .KEEP_MASK(keepMaskOf(g)),
        .RST_VAL  ((g == WI_STATUS) ? ERL_MASK : '0)
      ) uReg (
        .clk    (clk),
        .rstN   (rstN),
        .wrEn   (st.wrHit[g]),
        .wrData (wrData),
        .clrMask((g == WI_STATUS) ? retClr : '0),
        .q      (regQ[g])
      );
    end else begin : gPad
      assign regQ[g] = '0;
    end
  end

  always_comb begin
    case (st.rdSrc)
      SRC_REG:  rdMux = regQ[st.rdIdx];
      SRC_PRID: rdMux = PRID_VAL;
      SRC_CFG0: rdMux = CFG0_VAL;
      SRC_CFG1: rdMux = CFG1_VAL;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData    <= '0;
      rdValid   <= 1'b0;
      nextPc    <= '0;
      pcLoad    <= 1'b0;
      linkClr   <= 1'b0;
      timerIrq  <= 1'b0;
      badAccess <= 1'b0;
      unsupFlag <= 1'b0;
    end else begin
      rdValid   <= st.rdHit;
      rdData    <= st.rdHit ? rdMux : '0;
      badAccess <= st.bad;
      unsupFlag <= st.pgmBad;
      pcLoad    <= st.doRet;
      linkClr   <= st.doRet;
      if (st.doRet) nextPc <= erlNow ? regQ[WI_ERREPC] : regQ[WI_EPC];
      if (st.wrHit[WI_CMP])  timerIrq <= 1'b0;
      else if (timerEvent)   timerIrq <= 1'b1;
    end
  end

  // R7
  cmp_write_clears_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.wrHit[WI_CMP] |=> !timerIrq);

  // R8
  pgm_unchanged_on_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    unsupFlag |-> (regQ[WI_PGM] == $past(regQ[WI_PGM])));

  // R12
  erl_cleared_on_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && $past(erlNow)) |-> !erlNow);

  // R13
  exl_cleared_on_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && !$past(erlNow)) |-> !regQ[WI_STATUS][EXL_BIT]);
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int              INDEX_BITS = 4,
  parameter logic [XLEN-1:0] PRID_VAL   = 32'h0001_8000,
  parameter logic [XLEN-1:0] CFG0_VAL   = 32'h8000_8082,
  parameter logic [XLEN-1:0] CFG1_VAL   = 32'h1E19_0C8A
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [4:0]  regNum,
  input  logic [2:0]  regSel,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        rdValid,
  input  logic        retCmd,
  input  logic        inDelaySlot,
  output logic [31:0] nextPc,
  output logic        pcLoad,
  output logic        linkClr,
  input  logic        timerEvent,
  output logic        timerIrq,
  output logic        badAccess,
  output logic        unsupFlag
);
  ctrlStrobe_t st;

  sysctl_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regNum(regNum),
    .regSel(regSel), .wrData(wrData), .retCmd(retCmd),
    .inDelaySlot(inDelaySlot), .st(st)
  );

  sysctl_dp #(
    .INDEX_BITS(INDEX_BITS), .PRID_VAL(PRID_VAL),
    .CFG0_VAL(CFG0_VAL), .CFG1_VAL(CFG1_VAL)
  ) uDp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData), .timerEvent(timerEvent),
    .rdData(rdData), .rdValid(rdValid), .nextPc(nextPc), .pcLoad(pcLoad),
    .linkClr(linkClr), .timerIrq(timerIrq), .badAccess(badAccess),
    .unsupFlag(unsupFlag)
  );

  // R11
  delay_slot_return_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retCmd && inDelaySlot) |=> (!pcLoad && !linkClr));

  // R2
  read_valid_follows_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEn));

  // R10
  bad_read_no_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (badAccess && !$past(wrEn)) |-> !rdValid);
endmodule

// File: tb/sim_sysctl_regfile.sv
module sim_sysctl_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [4:0]  regNum = '0;
  logic [2:0]  regSel = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, nextPc;
  logic        rdValid, pcLoad, linkClr, timerIrq, badAccess, unsupFlag;
  logic        retCmd = 1'b0, inDelaySlot = 1'b0, timerEvent = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regfile u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regNum(regNum),
    .regSel(regSel), .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .retCmd(retCmd), .inDelaySlot(inDelaySlot), .nextPc(nextPc),
    .pcLoad(pcLoad), .linkClr(linkClr), .timerEvent(timerEvent),
    .timerIrq(timerIrq), .badAccess(badAccess), .unsupFlag(unsupFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // expected register contents after a write, from the requirement masks
  function automatic logic [31:0] expWrite(input logic [4:0] rn, input logic [31:0] old,
                                           input logic [31:0] d);
    case (rn)
      5'd0:  return (old & 32'h8000_0000) | (d & 32'h0000_000F);
      5'd6:  return d & 32'h0000_000F;
      5'd2, 5'd3: return d & 32'h03FF_FFFF;
      5'd10: return d & 32'hFFFF_E0FF;
      5'd4:  return (old & 32'h007F_FFFF) | (d & 32'hFF80_0000);
      5'd12: return (old & ~32'h7D7C_FF17) | (d & 32'h7D7C_FF17);
      5'd13: return (old & ~32'h00C0_FF00) | (d & 32'h00C0_FF00);
      default: return d;
    endcase
  endfunction

  task automatic doWrite(input logic [4:0] rn, input logic [2:0] sl, input logic [31:0] d,
                         output logic bad, output logic uns);
    wrEn = 1'b1; regNum = rn; regSel = sl; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    bad = badAccess; uns = unsupFlag;
  endtask

  task automatic doRead(input logic [4:0] rn, input logic [2:0] sl,
                        output logic [31:0] d, output logic v, output logic bad);
    rdEn = 1'b1; regNum = rn; regSel = sl;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData; v = rdValid; bad = badAccess;
  endtask

  task automatic doReturn(input logic ds, output logic ld, output logic lc,
                          output logic [31:0] pc);
    retCmd = 1'b1; inDelaySlot = ds;
    @(negedge clk);
    retCmd = 1'b0; inDelaySlot = 1'b0;
    ld = pcLoad; lc = linkClr; pc = nextPc;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
    finishRun();
  end

  initial begin
    logic [31:0] d;
    logic v, b, u, ld, lc;
    logic [4:0] wregs [12] = '{5'd0, 5'd2, 5'd3, 5'd4, 5'd6, 5'd9,
                                5'd10, 5'd11, 5'd12, 5'd13, 5'd14, 5'd30};
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 32; i++) model[i] = '0;
    model[12] = 32'h4;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 timerIrq", {31'b0, timerIrq}, 0);
    check("R1 pcLoad/linkClr", {30'b0, pcLoad, linkClr}, 0);
    check("R1 rdValid/badAccess", {30'b0, rdValid, badAccess}, 0);
    doRead(5'd12, 0, d, v, b);
    check("R1 status reset", d, 32'h4);
    check("R2 rdValid", {31'b0, v}, 1);
    doRead(5'd0, 0, d, v, b);
    check("R1 index reset", d, 0);
    check("R2 no stale valid", {31'b0, rdValid}, 1);
    @(negedge clk);
    check("R2 valid drops", {31'b0, rdValid}, 0);

    // R11 return in delay slot
    doReturn(1'b1, ld, lc, d);
    check("R11 no pcLoad", {30'b0, ld, lc}, 0);
    doRead(5'd12, 0, d, v, b);
    check("R11 status unchanged", d, 32'h4);

    // R12 error-level return
    doWrite(5'd14, 0, 32'h8000_1000, b, u); model[14] = 32'h8000_1000;
    doWrite(5'd30, 0, 32'hBFC0_0380, b, u); model[30] = 32'hBFC0_0380;
    doReturn(1'b0, ld, lc, d);
    check("R12 pcLoad+linkClr", {30'b0, ld, lc}, 32'h3);
    check("R12 nextPc", d, 32'hBFC0_0380);
    @(negedge clk);
    check("R12 one-cycle strobe", {31'b0, pcLoad}, 0);
    doRead(5'd12, 0, d, v, b);
    check("R12 erl cleared", d, 0);

    // R13 exception-level return
    doWrite(5'd12, 0, 32'h0000_0003, b, u);
    doReturn(1'b0, ld, lc, d);
    check("R13 pcLoad", {31'b0, ld}, 1);
    check("R13 nextPc", d, 32'h8000_1000);
    doRead(5'd12, 0, d, v, b);
    check("R13 exl cleared", d, 32'h1);
    model[12] = 32'h1;

    // R3 index / wired
    doWrite(5'd0, 0, 32'hFFFF_FFFF, b, u);
    doRead(5'd0, 0, d, v, b);
    check("R3 index mask", d, 32'hF);
    doWrite(5'd6, 0, 32'hFFFF_FFF5, b, u);
    doRead(5'd6, 0, d, v, b);
    check("R3 wired mask", d, 32'h5);
    model[0] = 32'hF; model[6] = 32'h5;

    // R4 entry-low ignores select, entry-high clears 12:8
    doWrite(5'd2, 3'd5, 32'hFFFF_FFFF, b, u);
    check("R4 lo select accepted", {31'b0, b}, 0);
    doRead(5'd2, 3'd2, d, v, b);
    check("R4 lo mask", d, 32'h03FF_FFFF);
    doWrite(5'd10, 0, 32'hFFFF_FFFF, b, u);
    doRead(5'd10, 0, d, v, b);
    check("R4 hi mask", d, 32'hFFFF_E0FF);
    model[2] = 32'h03FF_FFFF; model[10] = 32'hFFFF_E0FF;

    // R5 context
    doWrite(5'd4, 0, 32'hFFFF_FFFF, b, u);
    doRead(5'd4, 0, d, v, b);
    check("R5 context high bits", d, 32'hFF80_0000);
    model[4] = 32'hFF80_0000;

    // R6 status and cause masks
    doWrite(5'd13, 0, 32'hFFFF_FFFF, b, u);
    doRead(5'd13, 0, d, v, b);
    check("R6 cause mask", d, 32'h00C0_FF00);
    model[13] = 32'h00C0_FF00;

    // R7 timer interrupt
    timerEvent = 1'b1; @(negedge clk); timerEvent = 1'b0;
    check("R7 irq set", {31'b0, timerIrq}, 1);
    doWrite(5'd11, 0, 32'h1234, b, u); model[11] = 32'h1234;
    check("R7 irq cleared", {31'b0, timerIrq}, 0);
    timerEvent = 1'b1; doWrite(5'd11, 0, 32'h1234, b, u); timerEvent = 1'b0;
    check("R7 clear wins", {31'b0, timerIrq}, 0);

    // R8 page mask
    doWrite(5'd5, 0, 32'h0000_6000, b, u);
    check("R8 unsup flag", {31'b0, u}, 1);
    @(negedge clk);
    check("R8 flag one cycle", {31'b0, unsupFlag}, 0);
    doRead(5'd5, 0, d, v, b);
    check("R8 pgmask unchanged", d, 0);
    doWrite(5'd5, 0, 32'h0, b, u);
    check("R8 zero accepted", {30'b0, u, b}, 0);

    // R9 fixed values
    doRead(5'd15, 3'd3, d, v, b);
    check("R9 prid", d, 32'h0001_8000);
    doRead(5'd16, 0, d, v, b);
    check("R9 cfg sel0", d, 32'h8000_8082);
    doRead(5'd16, 3'd1, d, v, b);
    check("R9 cfg sel1", d, 32'h1E19_0C8A);
    doWrite(5'd18, 0, 32'hDEAD_BEEF, b, u);
    doRead(5'd18, 0, d, v, b);
    check("R9 reg18 zero", {v, d[30:0]}, 32'h8000_0000);
    doWrite(5'd19, 3'd2, 32'hDEAD_BEEF, b, u);
    doRead(5'd19, 3'd2, d, v, b);
    check("R9 reg19 zero", d, 0);
    doWrite(5'd16, 0, 32'h0, b, u);
    doRead(5'd16, 0, d, v, b);
    check("R9 cfg write ignored", d, 32'h8000_8082);

    // R10 undefined accesses
    doRead(5'd1, 0, d, v, b);
    check("R10 undefined read", {30'b0, v, b}, 32'h1);
    doRead(5'd16, 3'd2, d, v, b);
    check("R10 bad cfg select", {30'b0, v, b}, 32'h1);
    doWrite(5'd12, 3'd3, 32'hFFFF_FFFF, b, u);
    check("R10 bad write flag", {31'b0, b}, 1);
    @(negedge clk);
    check("R10 flag one cycle", {31'b0, badAccess}, 0);
    doRead(5'd12, 0, d, v, b);
    check("R10 status untouched", d, model[12]);
    doWrite(5'd15, 0, 32'h1, b, u);
    check("R10 prid write flagged", {31'b0, b}, 1);

    // random write/read pairs across writable registers (R3 R4 R5 R6 R10)
    for (int n = 0; n < 300; n++) begin
      logic [4:0] rn;
      logic [31:0] wd;
      rn = wregs[$urandom_range(0, 11)];
      wd = $urandom();
      doWrite(rn, 0, wd, b, u);
      model[rn] = expWrite(rn, model[rn], wd);
      doRead(rn, 0, d, v, b);
      check($sformatf("R6 random reg %0d", rn), d, model[rn]);
    end

    finishRun();
  end
endmodule